// File: doc/BRIEF.md
# Tagged Dual-Page-Size Translation Cache

This block is a fully associative translation cache. It keeps recent virtual-to-physical page mappings so that most address requests resolve without consulting the page tables in memory. It keeps two separate arrays that are searched in parallel. One holds 4 KB mappings and the other holds 2 MB mappings. Each array has its own capacity and its own replacement pointer.

Every entry is tagged with the identifier of the virtual processor that installed it. A lookup matches only entries that carry the requester's identifier. Switching from one virtual machine to another therefore needs no flush, and each machine's entries survive the other's activity. A lookup resolves combinationally in the cycle it is presented. On a miss, the requester is expected to retry once an external walker has found the mapping and written it through the fill port. Three kinds of invalidate command remove stale mappings.

Top module: `xlat_tlb`

## Requirements
- R1: A 4 KB entry hits when it is valid, its tag equals lookup address bits [31:12] and its identifier equals the lookup identifier. The returned address is the stored frame (bits [31:12]) joined with address bits [11:0], in the same cycle as the request.
- R2: A 2 MB entry hits when it is valid, its tag equals address bits [31:21] and its identifier matches. The returned address is the stored frame (bits [31:21]) joined with address bits [20:0].
- R3: Entries installed under one identifier never hit for another identifier. Entries of other identifiers are kept when lookups switch between identifiers.
- R4: With `lk_valid` high and no hit, `lk_miss` is 1 and `lk_hit` is 0. With `lk_valid` low, both are 0.
- R5: When both arrays hit, the 2 MB result is returned.
- R6: A fill is not seen by a lookup in the same cycle. It is seen from the next cycle on.
- R7: The 4 KB array holds 64 entries and the 2 MB array holds 32. A fill uses the lowest-numbered invalid entry. When the array is full, it evicts the entry at a per-array round-robin pointer. That pointer starts at 0 after reset and advances by one only on such an eviction.
- R8: A fill whose identifier and tag match a valid entry in its array overwrites that entry, so no duplicate is created.
- R9: Invalidate kind 2'b00 clears every entry in both arrays.
- R10: Invalidate kind 2'b01 clears every entry whose identifier equals `inv_vpid`, and leaves all other entries intact.
- R11: Invalidate kind 2'b10 clears entries of `inv_vpid` whose tag matches `inv_va` at the entry's own page size, in both arrays. Kind 2'b11 changes nothing.
- R12: When a fill and an invalidate occur in the same cycle, the invalidate is applied first. The filled entry is valid afterwards.
- R13: After reset every entry is invalid, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_va | input | 32 | Lookup virtual address |
| lk_vpid | input | 8 | Identifier of the requesting virtual processor |
| lk_hit | output | 1 | Lookup found a mapping |
| lk_miss | output | 1 | Lookup found nothing; retry after a fill |
| lk_pa | output | 32 | Translated physical address (0 when no hit) |
| fill_valid | input | 1 | Install a mapping this cycle |
| fill_large | input | 1 | 1 selects the 2 MB array, 0 the 4 KB array |
| fill_va | input | 32 | Virtual address of the mapping |
| fill_vpid | input | 8 | Identifier of the mapping |
| fill_pa | input | 32 | Physical address of the mapping |
| inv_valid | input | 1 | Invalidate command this cycle |
| inv_kind | input | 2 | 00 all, 01 one identifier, 10 one page of one identifier, 11 none |
| inv_vpid | input | 8 | Identifier for kinds 01 and 10 |
| inv_va | input | 32 | Address for kind 10 |

## Verification
The hardest situations to reach from the ports are round-robin eviction and the case where both arrays hit. Eviction only happens once an array is completely full. The bench first flushes everything, then fills all 64 small slots and all 32 large slots under fresh identifiers. It then issues further fills and checks which of the oldest mappings disappear, and in which order. For the double hit, a 4 KB page is placed inside an already cached 2 MB region. Invalidating that 2 MB region afterwards exposes the small entry underneath, which confirms it was there all along.

// File: rtl/xlat_pkg.sv
// Shared definitions for the tagged translation cache.
// Assumes: invalidate kind is carried as a 2-bit code on the ports.
package xlat_pkg;
    typedef enum logic [1:0] {
        INV_ALL  = 2'b00,
        INV_VPID = 2'b01,
        INV_PAGE = 2'b10,
        INV_NOP  = 2'b11
    } inv_kind_e;
endpackage

// File: rtl/xlat_rr.sv
// Round-robin victim pointer for one array.
// Assumes: advance is pulsed only when a fill evicts a valid entry.
module xlat_rr #(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [IDX_W-1:0] ptr
);
    // Step the pointer on each eviction, wrapping at DEPTH-1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (advance)
            ptr <= (ptr == IDX_W'(DEPTH - 1)) ? '0 : ptr + 1'b1;
    end

    p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(ptr));
endmodule

// File: rtl/xlat_bank.sv
// One fully associative array of same-size page mappings.
// Performs the lookup match, slot choice for fills and invalidates.
// Assumes: the tag and frame inputs are already sliced for this page size.
module xlat_bank
    import xlat_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int TAG_W   = 20,
    parameter int FRAME_W = 20,
    parameter int VPID_W  = 8,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TAG_W-1:0]   lk_tag,
    input  logic [VPID_W-1:0]  lk_vpid,
    output logic               lk_hit,
    output logic [FRAME_W-1:0] lk_frame,
    input  logic               fill_en,
    input  logic [TAG_W-1:0]   fill_tag,
    input  logic [VPID_W-1:0]  fill_vpid,
    input  logic [FRAME_W-1:0] fill_frame,
    input  logic               inv_en,
    input  logic [1:0]         inv_kind,
    input  logic [VPID_W-1:0]  inv_vpid,
    input  logic [TAG_W-1:0]   inv_tag
);
    logic [DEPTH-1:0]   valid_q;
    logic [TAG_W-1:0]   tag_q   [DEPTH];
    logic [VPID_W-1:0]  vpid_q  [DEPTH];
    logic [FRAME_W-1:0] frame_q [DEPTH];

    logic [DEPTH-1:0] lk_match, fill_match, inv_sel;
    logic             dup_any, free_any, use_ptr;
    logic [IDX_W-1:0] dup_idx, free_idx, fill_idx, rr_ptr;

    // Per-entry compare for lookup, duplicate detection and invalidate.
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign lk_match[i]   = valid_q[i] && tag_q[i] == lk_tag && vpid_q[i] == lk_vpid;
        assign fill_match[i] = valid_q[i] && tag_q[i] == fill_tag && vpid_q[i] == fill_vpid;
        assign inv_sel[i]    = (inv_kind == INV_ALL) ||
                               (inv_kind == INV_VPID && vpid_q[i] == inv_vpid) ||
                               (inv_kind == INV_PAGE && vpid_q[i] == inv_vpid &&
                                tag_q[i] == inv_tag);
    end

    // OR-merge the frame of the (unique) matching entry.
    always_comb begin
        lk_frame = '0;
        for (int i = 0; i < DEPTH; i++)
            if (lk_match[i]) lk_frame |= frame_q[i];
    end
    assign lk_hit = |lk_match;

    // Lowest-index duplicate and lowest-index free slot.
    always_comb begin
        dup_any  = 1'b0;
        free_any = 1'b0;
        dup_idx  = '0;
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (fill_match[i]) begin dup_any = 1'b1;  dup_idx  = IDX_W'(i); end
            if (!valid_q[i])   begin free_any = 1'b1; free_idx = IDX_W'(i); end
        end
    end

    // Pick the slot: overwrite duplicate, else first free, else victim pointer.
    always_comb begin
        use_ptr  = fill_en && !dup_any && !free_any;
        fill_idx = dup_any ? dup_idx : (free_any ? free_idx : rr_ptr);
    end

    xlat_rr #(.DEPTH(DEPTH)) u_rr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (use_ptr),
        .ptr     (rr_ptr)
    );

    // Valid bits: invalidate first, then the fill slot is set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++)
                if (inv_en && inv_sel[i]) valid_q[i] <= 1'b0;
            if (fill_en) valid_q[fill_idx] <= 1'b1;
        end
    end

    // Entry payload written on fill; no reset needed behind valid.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[fill_idx]   <= fill_tag;
            vpid_q[fill_idx]  <= fill_vpid;
            frame_q[fill_idx] <= fill_frame;
        end
    end

    p_unique_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));
    p_fill_lands_r12: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> valid_q[$past(fill_idx)]);
    p_flush_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_en && inv_kind == INV_ALL && !fill_en) |=> (valid_q == '0));
endmodule

// File: rtl/xlat_tlb.sv
// Tagged translation cache with a 4 KB array and a 2 MB array searched in
// parallel. Lookup is combinational; fills and invalidates take effect on
// the next clock edge. Assumes the fill source supplies page-aligned frames.
module xlat_tlb #(
    parameter int VA_W          = 32,
    parameter int PA_W          = 32,
    parameter int VPID_W        = 8,
    parameter int SMALL_ENTRIES = 64,
    parameter int LARGE_ENTRIES = 32,
    parameter int SMALL_OFF     = 12,
    parameter int LARGE_OFF     = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [VPID_W-1:0] lk_vpid,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic [PA_W-1:0]   lk_pa,
    input  logic              fill_valid,
    input  logic              fill_large,
    input  logic [VA_W-1:0]   fill_va,
    input  logic [VPID_W-1:0] fill_vpid,
    input  logic [PA_W-1:0]   fill_pa,
    input  logic              inv_valid,
    input  logic [1:0]        inv_kind,
    input  logic [VPID_W-1:0] inv_vpid,
    input  logic [VA_W-1:0]   inv_va
);
    localparam int S_TAG = VA_W - SMALL_OFF;
    localparam int S_FRM = PA_W - SMALL_OFF;
    localparam int L_TAG = VA_W - LARGE_OFF;
    localparam int L_FRM = PA_W - LARGE_OFF;

    logic             s_hit, l_hit;
    logic [S_FRM-1:0] s_frame;
    logic [L_FRM-1:0] l_frame;

    xlat_bank #(.DEPTH(SMALL_ENTRIES), .TAG_W(S_TAG), .FRAME_W(S_FRM),
                .VPID_W(VPID_W)) u_small (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_tag     (lk_va[VA_W-1:SMALL_OFF]),
        .lk_vpid    (lk_vpid),
        .lk_hit     (s_hit),
        .lk_frame   (s_frame),
        .fill_en    (fill_valid && !fill_large),
        .fill_tag   (fill_va[VA_W-1:SMALL_OFF]),
        .fill_vpid  (fill_vpid),
        .fill_frame (fill_pa[PA_W-1:SMALL_OFF]),
        .inv_en     (inv_valid),
        .inv_kind   (inv_kind),
        .inv_vpid   (inv_vpid),
        .inv_tag    (inv_va[VA_W-1:SMALL_OFF])
    );

    xlat_bank #(.DEPTH(LARGE_ENTRIES), .TAG_W(L_TAG), .FRAME_W(L_FRM),
                .VPID_W(VPID_W)) u_large (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_tag     (lk_va[VA_W-1:LARGE_OFF]),
        .lk_vpid    (lk_vpid),
        .lk_hit     (l_hit),
        .lk_frame   (l_frame),
        .fill_en    (fill_valid && fill_large),
        .fill_tag   (fill_va[VA_W-1:LARGE_OFF]),
        .fill_vpid  (fill_vpid),
        .fill_frame (fill_pa[PA_W-1:LARGE_OFF]),
        .inv_en     (inv_valid),
        .inv_kind   (inv_kind),
        .inv_vpid   (inv_vpid),
        .inv_tag    (inv_va[VA_W-1:LARGE_OFF])
    );

    // Merge results: large page takes priority over small page.
    always_comb begin
        lk_hit  = lk_valid && (s_hit || l_hit);
        lk_miss = lk_valid && !(s_hit || l_hit);
        if (!lk_valid)  lk_pa = '0;
        else if (l_hit) lk_pa = {l_frame, lk_va[LARGE_OFF-1:0]};
        else if (s_hit) lk_pa = {s_frame, lk_va[SMALL_OFF-1:0]};
        else            lk_pa = '0;
    end

    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !lk_miss));
    p_large_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && l_hit) |-> (lk_pa[PA_W-1:LARGE_OFF] == l_frame));
endmodule

// File: tb/xlat_tlb_test.sv
`timescale 1ns/1ps
module xlat_tlb_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0, lk_hit, lk_miss;
    logic [31:0] lk_va = '0, lk_pa;
    logic [7:0]  lk_vpid = '0;
    logic        fill_valid = 1'b0, fill_large = 1'b0;
    logic [31:0] fill_va = '0, fill_pa = '0;
    logic [7:0]  fill_vpid = '0;
    logic        inv_valid = 1'b0;
    logic [1:0]  inv_kind = '0;
    logic [7:0]  inv_vpid = '0;
    logic [31:0] inv_va = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic        vld;
        logic        hit;
        logic [31:0] pa;
        string       req;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    xlat_tlb uut (.*);

    task automatic quiet();
        lk_valid = 0; fill_valid = 0; inv_valid = 0;
    endtask

    task automatic push(input logic v, input logic h, input logic [31:0] pa, input string r);
        exp_t e;
        e.vld = v; e.hit = h; e.pa = pa; e.req = r;
        sb.push_back(e);
    endtask

    task automatic set_look(input logic [31:0] va, input logic [7:0] id);
        lk_valid = 1; lk_va = va; lk_vpid = id;
    endtask

    task automatic set_fill(input logic lg, input logic [31:0] va, input logic [7:0] id,
                            input logic [31:0] pa);
        fill_valid = 1; fill_large = lg; fill_va = va; fill_vpid = id; fill_pa = pa;
    endtask

    task automatic set_inv(input logic [1:0] k, input logic [7:0] id, input logic [31:0] va);
        inv_valid = 1; inv_kind = k; inv_vpid = id; inv_va = va;
    endtask

    task automatic look(input logic [31:0] va, input logic [7:0] id, input logic h,
                        input logic [31:0] pa, input string r);
        @(negedge clk); quiet(); set_look(va, id); push(1, h, pa, r);
    endtask

    task automatic fill(input logic lg, input logic [31:0] va, input logic [7:0] id,
                        input logic [31:0] pa);
        @(negedge clk); quiet(); set_fill(lg, va, id, pa);
    endtask

    task automatic inval(input logic [1:0] k, input logic [7:0] id, input logic [31:0] va);
        @(negedge clk); quiet(); set_inv(k, id, va);
    endtask

    // Monitor: compare outputs against the oldest expected item mid-cycle.
    always begin
        @(negedge clk);
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (lk_hit !== e.hit || lk_miss !== (e.vld && !e.hit) ||
                (e.hit && lk_pa !== e.pa)) begin
                errors++;
                $display("FAIL %s: hit=%b miss=%b pa=%h expected hit=%b miss=%b pa=%h",
                         e.req, lk_hit, lk_miss, lk_pa, e.hit, e.vld && !e.hit, e.pa);
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R13: empty after reset; R4 idle gives neither hit nor miss
        look(32'h1234_5678, 8'd1, 0, '0, "R13");
        @(negedge clk); quiet(); push(0, 0, '0, "R4 idle");
        // R6: fill and lookup in the same cycle -> miss, then hit (R1)
        @(negedge clk); quiet();
        set_fill(0, 32'h0040_3000, 8'd1, 32'h8765_4000);
        set_look(32'h0040_3abc, 8'd1); push(1, 0, '0, "R6 same cycle");
        look(32'h0040_3abc, 8'd1, 1, 32'h8765_4abc, "R1/R6");
        // R3: identifier isolation
        look(32'h0040_3abc, 8'd2, 0, '0, "R3 other id");
        fill(0, 32'h0040_3000, 8'd2, 32'h1111_1000);
        look(32'h0040_3abc, 8'd2, 1, 32'h1111_1abc, "R3 id2");
        look(32'h0040_3abc, 8'd1, 1, 32'h8765_4abc, "R3 id1 kept");
        // R2: large page
        fill(1, 32'h0060_0000, 8'd1, 32'h4020_0000);
        look(32'h0071_2345, 8'd1, 1, 32'h4031_2345, "R2");
        // R5: small page inside cached large region
        fill(0, 32'h0070_0000, 8'd1, 32'h9999_9000);
        look(32'h0070_0010, 8'd1, 1, 32'h4030_0010, "R5");
        // R8: refill in place
        fill(0, 32'h0040_3000, 8'd1, 32'h2222_2000);
        look(32'h0040_3004, 8'd1, 1, 32'h2222_2004, "R8 new frame");
        inval(2'b10, 8'd1, 32'h0040_3000);
        look(32'h0040_3004, 8'd1, 0, '0, "R8/R11 no stale copy");
        look(32'h0040_3004, 8'd2, 1, 32'h1111_1004, "R11 other id kept");
        // R11: page invalidate of large region exposes small entry
        inval(2'b10, 8'd1, 32'h0065_0000);
        look(32'h0070_0010, 8'd1, 1, 32'h9999_9010, "R11 large removed");
        inval(2'b11, 8'd1, 32'h0070_0000);
        look(32'h0070_0010, 8'd1, 1, 32'h9999_9010, "R11 kind 11 no effect");
        // R10: per-identifier invalidate
        inval(2'b01, 8'd2, '0);
        look(32'h0040_3abc, 8'd2, 0, '0, "R10 id2 gone");
        look(32'h0070_0010, 8'd1, 1, 32'h9999_9010, "R10 id1 kept");
        // R9: flush everything
        inval(2'b00, '0, '0);
        look(32'h0070_0010, 8'd1, 0, '0, "R9");
        // R12: fill with same-cycle flush survives
        @(negedge clk); quiet();
        set_fill(0, 32'h0000_5000, 8'd3, 32'h0000_a000);
        set_inv(2'b00, '0, '0);
        look(32'h0000_5123, 8'd3, 1, 32'h0000_a123, "R12");
        // R7: small array capacity and round-robin eviction
        inval(2'b00, '0, '0);
        for (int i = 0; i < 64; i++) fill(0, 32'(i) << 12, 8'd4, 32'(i + 256) << 12);
        look(32'h0000_0000, 8'd4, 1, 32'h0010_0000, "R7 small full");
        look(32'(63) << 12, 8'd4, 1, 32'(319) << 12, "R7 small last");
        fill(0, 32'(64) << 12, 8'd4, 32'(320) << 12);
        look(32'h0000_0000, 8'd4, 0, '0, "R7 slot0 evicted");
        look(32'h0000_1000, 8'd4, 1, 32'(257) << 12, "R7 slot1 kept");
        look(32'(64) << 12, 8'd4, 1, 32'(320) << 12, "R7 new entry");
        fill(0, 32'(65) << 12, 8'd4, 32'(321) << 12);
        look(32'h0000_1000, 8'd4, 0, '0, "R7 slot1 evicted");
        look(32'h0000_2000, 8'd4, 1, 32'(258) << 12, "R7 slot2 kept");
        // R7: large array capacity
        for (int j = 0; j < 32; j++) fill(1, 32'(j) << 21, 8'd5, 32'(j + 64) << 21);
        look(32'(31) << 21, 8'd5, 1, 32'(95) << 21, "R7 large full");
        fill(1, 32'(32) << 21, 8'd5, 32'(96) << 21);
        look(32'h0000_0000, 8'd5, 0, '0, "R7 large slot0 evicted");
        look(32'(1) << 21, 8'd5, 1, 32'(65) << 21, "R7 large slot1 kept");
        @(negedge clk); quiet();
        repeat (2) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule